// File: doc/BRIEF.md
# Indirect Register Access Port

This block is a bus-slave front end that lets a host reach a bank of internal 32-bit registers through a small, directly decoded window of eight word offsets. The host never addresses the internal bank directly. To store a value, it first stages the low and high halfwords in two 16-bit data registers. It then writes the index register, and that write acts as the command that launches the internal access. To fetch a value, it writes the index register with the read flag set. When the access completes, the fetched word lands in the same two data registers.

Each internal access takes a parameterised number of cycles. While it runs, a busy bit in the status register stays high, and software polls that bit until it clears. A second index write during that time is refused and raises a sticky error flag. The status register also drives two active-low reset outputs, one for the whole function and one for the codec. A read-only version register reports a three-part version number and a presence flag.

Top module: `ira_port`

## Requirements
- R1: After reset, the status word reads 0 (not busy, no error, both resets asserted), all data registers and every internal register hold 0, and both reset outputs are low.
- R2: The window decodes host_addr as follows: 0 status, 1 index, 2 to 5 data registers 0 to 3, 6 version, 7 unused and reads 0. Data registers keep only bits 15:0 of a write, and their bits 31:16 read as 0.
- R3: Writing the index register with bit 15 clear stores {data1, data0}, taken at the moment of the index write, into the internal register selected by index bits IDX_W-1:0.
- R4: Writing the index register with bit 15 set fetches the selected internal register. On completion, data0 takes bits 15:0 and data1 takes bits 31:16, while data2 and data3 keep their values.
- R5: Status bit 0 (busy) reads 1 from the clock edge that accepts the index write for exactly LAT cycles, and reads 0 afterwards.
- R6: An index write while busy is set is ignored: it starts no access and leaves the index register and the internal bank unchanged. It sets status bit 1 (error), which stays set until a status write with bit 1 set clears it.
- R7: During a busy period, reads of the data registers return their previous contents until the access completes.
- R8: Status bit 3 drives glob_rst_n and status bit 4 drives codec_rst_n. Writing 0 to the status register asserts both resets (outputs low), and writing both bits as 1 releases both.
- R9: The version register reads {16'h0, absent, major[2:0], 4'h0, minor[3:0], rev[3:0]}. Major sits in bits 14:12, minor in 7:4, revision in 3:0, and bit 15 clear means the audio function is present. With the defaults it reads 0x1023.
- R10: When a read completion and a host write to data0 or data1 fall in the same cycle, the completion value is kept.
- R11: The index register reads back the last accepted command, with the read flag in bit 15 and the index in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, qualifies a write |
| host_we | input | 1 | Host write enable |
| host_addr | input | 3 | Window word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| glob_rst_n | output | 1 | Active-low global reset output |
| codec_rst_n | output | 1 | Active-low codec reset output |

## Verification
A read access completes by loading data0 and data1, and a host write can target those same registers, so both can land on one clock edge. The bench launches a fetch and counts the LAT cycles to the completion edge, then times a host write to data0 so that it is accepted on that exact edge. A later read of data0 must return the fetched halfword and not the host value. A second collision is also provoked: an index write arriving during busy, which must leave the running access and the index readback unchanged while raising the error bit.

// File: rtl/ira_pkg.sv
package ira_pkg;

    localparam int DATA_W     = 16;
    localparam int IDX_RD_BIT = 15;

    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_GRST = 3;
    localparam int ST_CRST = 4;

    typedef enum logic [2:0] {
        WIN_STAT = 3'd0,
        WIN_IDX  = 3'd1,
        WIN_D0   = 3'd2,
        WIN_D1   = 3'd3,
        WIN_D2   = 3'd4,
        WIN_D3   = 3'd5,
        WIN_VER  = 3'd6,
        WIN_NONE = 3'd7
    } win_off_e;

    typedef struct packed {
        logic        rd;
        logic [31:0] wdata;
    } xfer_t;

    function automatic logic [31:0] ver_word(input logic absent, input logic [2:0] maj,
                                             input logic [3:0] mnr, input logic [3:0] rev);
        return {16'h0, absent, maj, 4'h0, mnr, rev};
    endfunction

endpackage

// File: rtl/ira_bank.sv
module ira_bank #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_word
);
    localparam int NREG = 1 << IDX_W;

    logic [31:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) mem[k] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rd_word = mem[idx];

    // R3: a committed write is visible in the addressed entry on the next cycle
    assert_bank_wr_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/ira_seq.sv
module ira_seq
    import ira_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LAT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [IDX_W-1:0] launch_idx,
    input  xfer_t            launch_req,
    output logic             busy,
    output logic             done,
    output logic             done_rd,
    output logic             bank_we,
    output logic [IDX_W-1:0] bank_idx,
    output logic [31:0]      bank_wdata
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]    cnt;
    logic             busy_q;
    logic [IDX_W-1:0] cur_idx;
    xfer_t            cur_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt     <= '0;
            cur_idx <= '0;
            cur_req <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            cnt     <= CW'(LAT - 1);
            cur_idx <= launch_idx;
            cur_req <= launch_req;
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign busy       = busy_q;
    assign done       = busy_q && (cnt == '0);
    assign done_rd    = done && cur_req.rd;
    assign bank_we    = done && !cur_req.rd;
    assign bank_idx   = cur_idx;
    assign bank_wdata = cur_req.wdata;

    // R5: an accepted command raises busy on the next cycle
    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);
    // R5: completion drops busy
    assert_done_clear_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R6: the front end never launches while an access runs
    assert_no_launch_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !launch);

endmodule

// File: rtl/ira_window.sv
module ira_window
    import ira_pkg::*;
#(
    parameter int          IDX_W   = 4,
    parameter logic [31:0] VER_VAL = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_sel,
    input  logic             host_we,
    input  logic [2:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic             done_rd,
    input  logic [31:0]      rd_word,
    output logic             launch,
    output logic [IDX_W-1:0] launch_idx,
    output xfer_t            launch_req,
    output logic             glob_rst_n,
    output logic             codec_rst_n
);
    logic [DATA_W-1:0] dreg [4];
    logic [IDX_W-1:0]  idx_q;
    logic              idx_rd;
    logic              err_q, grst_q, crst_q;
    logic              wr_hit, idx_wr, reject, stat_wr;
    logic              unused_hi;

    assign wr_hit  = host_sel && host_we;
    assign idx_wr  = wr_hit && (host_addr == WIN_IDX);
    assign stat_wr = wr_hit && (host_addr == WIN_STAT);
    assign launch  = idx_wr && !busy;
    assign reject  = idx_wr && busy;

    assign launch_idx       = host_wdata[IDX_W-1:0];
    assign launch_req.rd    = host_wdata[IDX_RD_BIT];
    assign launch_req.wdata = {dreg[1], dreg[0]};
    assign unused_hi        = ^host_wdata[31:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) dreg[k] <= '0;
            idx_q  <= '0;
            idx_rd <= 1'b0;
            err_q  <= 1'b0;
            grst_q <= 1'b0;
            crst_q <= 1'b0;
        end else begin
            if (launch) begin
                idx_q  <= host_wdata[IDX_W-1:0];
                idx_rd <= host_wdata[IDX_RD_BIT];
            end
            if (stat_wr) begin
                grst_q <= host_wdata[ST_GRST];
                crst_q <= host_wdata[ST_CRST];
                if (host_wdata[ST_ERR]) err_q <= 1'b0;
            end
            if (reject) err_q <= 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (wr_hit && (int'(host_addr) == int'(WIN_D0) + k))
                    dreg[k] <= host_wdata[DATA_W-1:0];
            end
            if (done_rd) begin
                dreg[0] <= rd_word[15:0];
                dreg[1] <= rd_word[31:16];
            end
        end
    end

    always_comb begin
        case (win_off_e'(host_addr))
            WIN_STAT: host_rdata = 32'({crst_q, grst_q, 1'b0, err_q, busy});
            WIN_IDX:  host_rdata = 32'(idx_q) | (32'(idx_rd) << IDX_RD_BIT);
            WIN_D0:   host_rdata = 32'(dreg[0]);
            WIN_D1:   host_rdata = 32'(dreg[1]);
            WIN_D2:   host_rdata = 32'(dreg[2]);
            WIN_D3:   host_rdata = 32'(dreg[3]);
            WIN_VER:  host_rdata = VER_VAL;
            default:  host_rdata = 32'h0;
        endcase
    end

    assign glob_rst_n  = grst_q;
    assign codec_rst_n = crst_q;

    // R6: a command arriving while busy leaves the error flag set
    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && busy) |=> err_q);
    // R4: a read completion loads the fetched halfwords
    assert_rd_load_R4: assert property (@(posedge clk) disable iff (rst)
        done_rd |=> (dreg[0] == $past(rd_word[15:0]) && dreg[1] == $past(rd_word[31:16])));
    // R7: data0 holds during busy unless the host writes it
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !(wr_hit && host_addr == WIN_D0)) |=> $stable(dreg[0]));
    // R8: a status write of zero asserts both resets
    assert_rst_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && host_wdata[ST_CRST:ST_GRST] == 2'b00) |=> (!glob_rst_n && !codec_rst_n));

endmodule

// File: rtl/ira_port.sv
module ira_port
    import ira_pkg::*;
#(
    parameter int         IDX_W        = 4,
    parameter int         LAT          = 4,
    parameter logic [2:0] VER_MAJ      = 3'd1,
    parameter logic [3:0] VER_MIN      = 4'd2,
    parameter logic [3:0] VER_REV      = 4'd3,
    parameter logic       AUDIO_ABSENT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        glob_rst_n,
    output logic        codec_rst_n
);
    localparam logic [31:0] VER_VAL = ver_word(AUDIO_ABSENT, VER_MAJ, VER_MIN, VER_REV);

    logic             busy, done, done_rd, launch, bank_we;
    logic [IDX_W-1:0] launch_idx, bank_idx;
    logic [31:0]      bank_wdata, rd_word;
    xfer_t            launch_req;

    ira_window #(.IDX_W(IDX_W), .VER_VAL(VER_VAL)) u_window (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .done_rd(done_rd), .rd_word(rd_word),
        .launch(launch), .launch_idx(launch_idx), .launch_req(launch_req),
        .glob_rst_n(glob_rst_n), .codec_rst_n(codec_rst_n)
    );

    ira_seq #(.IDX_W(IDX_W), .LAT(LAT)) u_seq (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_idx(launch_idx), .launch_req(launch_req),
        .busy(busy), .done(done), .done_rd(done_rd),
        .bank_we(bank_we), .bank_idx(bank_idx), .bank_wdata(bank_wdata)
    );

    ira_bank #(.IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst),
        .we(bank_we), .idx(bank_idx), .wdata(bank_wdata), .rd_word(rd_word)
    );

endmodule

// File: tb/ira_port_tb.sv
module ira_port_tb;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        glob_rst_n, codec_rst_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic mon_req = 1'b0;
    logic finished = 1'b0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    ira_port #(.LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .glob_rst_n(glob_rst_n), .codec_rst_n(codec_rst_n)
    );

    // scoreboard monitor: pops one expected item per sampled read
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_cmp++;
            if (host_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: read actual %h expected %h", r, host_rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] off, input logic [31:0] d);
        @(posedge clk); #1;
        host_sel = 1'b1; host_we = 1'b1; host_addr = off; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, input logic [31:0] e, input string r);
        @(posedge clk); #1;
        host_addr = off;
        exp_q.push_back(e);
        req_q.push_back(r);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic chk_port(input string r, input logic [31:0] a, input logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: port actual %h expected %h", r, a, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic xfer(input logic [31:0] cmd);
        wr(3'd1, cmd);
        idle(LAT + 2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        idle(4);
        #1 rst = 1'b0;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 status");
        rd(3'd2, 32'h0, "R1 data0");
        @(negedge clk);
        chk_port("R1 resets low", {30'h0, glob_rst_n, codec_rst_n}, 32'h0);
        // R9 version, R2 unused offset
        rd(3'd6, 32'h0000_1023, "R9 version");
        rd(3'd7, 32'h0, "R2 unused offset");
        // R8 release resets
        wr(3'd0, 32'h18);
        @(negedge clk);
        chk_port("R8 release", {30'h0, glob_rst_n, codec_rst_n}, 32'h3);
        rd(3'd0, 32'h18, "R8 status");
        // R2 data register width
        wr(3'd2, 32'hFFFF_BEEF);
        wr(3'd3, 32'h0000_CAFE);
        wr(3'd4, 32'h0000_1111);
        wr(3'd5, 32'h0000_2222);
        rd(3'd2, 32'h0000_BEEF, "R2 data0 upper zero");
        rd(3'd4, 32'h0000_1111, "R2 data2");
        rd(3'd5, 32'h0000_2222, "R2 data3");
        // R5 busy window for a write access to index 5
        wr(3'd1, 32'h0000_0005);
        rd(3'd0, 32'h19, "R5 busy cycle 1");
        rd(3'd0, 32'h19, "R5 busy cycle 2");
        rd(3'd0, 32'h19, "R5 busy cycle 3");
        rd(3'd0, 32'h18, "R5 busy cleared");
        // R4/R7/R11 read access of index 5
        wr(3'd2, 32'h0000_1234);
        wr(3'd1, 32'h0000_8005);
        rd(3'd2, 32'h0000_1234, "R7 data0 held");
        rd(3'd3, 32'h0000_CAFE, "R7 data1 held");
        rd(3'd1, 32'h0000_8005, "R11 index readback");
        rd(3'd2, 32'h0000_BEEF, "R4 data0 loaded");
        rd(3'd3, 32'h0000_CAFE, "R4 data1 loaded");
        rd(3'd4, 32'h0000_1111, "R4 data2 untouched");
        // R6 command while busy
        wr(3'd2, 32'h0000_0A0A);
        wr(3'd3, 32'h0000_0B0B);
        wr(3'd1, 32'h0000_0007);
        wr(3'd1, 32'h0000_0009);
        rd(3'd0, 32'h1B, "R6 error while busy");
        idle(LAT + 2);
        rd(3'd1, 32'h0000_0007, "R6 index unchanged");
        xfer(32'h0000_8009);
        rd(3'd2, 32'h0, "R6 index 9 not written");
        xfer(32'h0000_8007);
        rd(3'd2, 32'h0000_0A0A, "R3 index 7 low");
        rd(3'd3, 32'h0000_0B0B, "R3 index 7 high");
        rd(3'd0, 32'h1A, "R6 error sticky");
        wr(3'd0, 32'h1A);
        rd(3'd0, 32'h18, "R6 error cleared");
        // R10 completion collides with a host write to data0
        wr(3'd2, 32'h0000_5555);
        wr(3'd3, 32'h0000_6666);
        xfer(32'h0000_0003);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0000_8003);
        idle(2);
        wr(3'd2, 32'h0000_7777);
        rd(3'd2, 32'h0000_5555, "R10 completion wins data0");
        rd(3'd3, 32'h0000_6666, "R10 data1");
        // R3 top index boundary
        wr(3'd2, 32'h0000_FFFF);
        wr(3'd3, 32'h0000_FFFF);
        xfer(32'h0000_000F);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        xfer(32'h0000_800F);
        rd(3'd2, 32'h0000_FFFF, "R3 index 15 low");
        rd(3'd3, 32'h0000_FFFF, "R3 index 15 high");
        // R8 assert both resets again
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk_port("R8 assert", {30'h0, glob_rst_n, codec_rst_n}, 32'h0);
        rd(3'd0, 32'h0, "R8 status zero");
        idle(2);
        finish_run();
    end
endmodule